// File: doc/BRIEF.md
# Input Capture Period Meter

This block measures the time between successive rising edges of an asynchronous digital input, counted in timebase ticks. A narrow free-running timebase counter is widened in hardware by a second counter that advances every time the narrow one wraps. Together they form one wide timestamp. On each qualified rising edge of the synchronized input the block takes the current wide timestamp and subtracts the one taken at the previous edge. The difference is the period. It is presented for one clock cycle with a valid strobe.

Because wraps of the narrow counter are folded into the timestamp, periods far longer than one pass of the narrow counter are reported correctly. A selectable power-of-two prescaler slows the tick rate. A larger setting reaches lower input frequencies at the cost of coarser resolution. If so many wraps pass between two edges that the wide timestamp can no longer be trusted, the next result is pinned at its maximum value and flagged as out of range.

Top module: `pulse_period_meter`

## Requirements
- R1: The input passes through a two-stage synchronizer. Only a low-to-high change of the synchronized input is a capture event, and a falling edge produces no output. Each capture is reported on the third rising clock edge after the input rises.
- R2: `valid_o` is high for exactly one clock cycle per reported capture and is low otherwise.
- R3: The first capture after reset produces no valid output. It only records its timestamp as the reference for the next capture.
- R4: `period_o` equals the number of timebase ticks between the two latest captures. It is computed as the difference of the two wide timestamps modulo 2^(TB_W+RO_W).
- R5: The narrow timebase counter is TB_W bits wide and wraps from all-ones to zero. Each wrap increments the RO_W-bit rollover counter, so periods longer than 2^TB_W ticks are reported exactly.
- R6: With `psc_sel` = s, the timebase advances once every 2^s clock cycles. An input period of N clock cycles, with N a multiple of 2^s, reports N/2^s.
- R7: When a timebase wrap falls in the same cycle as a capture, the captured value is full scale. That wrap is counted towards the following interval, not the one just closed.
- R8: The block counts wraps since the last capture, saturating at 2^RO_W-1. If the count is saturated when the next capture arrives, that capture reports `period_o` all ones with `ovf_o` = 1. Any other capture reports `ovf_o` = 0.
- R9: While reset is asserted, `period_o` is zero and `valid_o` and `ovf_o` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for all logic and the timebase |
| rst_n | input | 1 | Asynchronous active-low reset |
| sig_in | input | 1 | Asynchronous signal whose period is measured |
| psc_sel | input | PSC_SEL_W | Prescaler exponent; tick every 2^psc_sel cycles |
| period_o | output | TB_W+RO_W | Ticks between the two latest captures |
| valid_o | output | 1 | One-cycle strobe marking a new period |
| ovf_o | output | 1 | Range overflow for the reported period |

## Verification
A rising input driven on a falling clock edge is captured on the third rising clock edge that follows: two synchronizer stages, then the capture register. The bench therefore samples period, strobe and flag on the third falling edge after it drives the input high. It also confirms that the strobe is low one cycle after the rise and three cycles after the fall. The sweep covers every input gap from 4 to 95 cycles and a reduced timebase, so captures land on every timebase phase, wrap cycles included. The prescaled settings and the overflow cases follow the same sampling rule. After each prescaler change, one interval with an unknown tick phase is skipped.

// File: rtl/ppm_pkg.sv
package ppm_pkg;

   // Reference register state: empty after reset, loaded after the first capture.
   typedef enum logic [0:0] {
      ARM_WAIT  = 1'b0,
      ARM_READY = 1'b1
   } arm_state_e;

   // Width of the prescaler counter. It must hold 2^(2^sel_w - 1) - 1.
   function automatic int unsigned psc_cnt_width(input int unsigned sel_w);
      int unsigned w;
      w = (1 << sel_w) - 1;
      return (w == 0) ? 1 : w;
   endfunction

endpackage

// File: rtl/ppm_sync_edge.sv
module ppm_sync_edge #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_i,
   output logic rise_o
);

   logic [STAGES-1:0] chain_q;
   logic              last_q;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("ppm_sync_edge: STAGES must be at least 2");
      end
   endgenerate

   // Synchronizer chain, one flop per stage.
   genvar gi;
   generate
      for (gi = 0; gi < STAGES; gi++) begin : g_stage
         if (gi == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[gi] <= 1'b0;
               else        chain_q[gi] <= async_i;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[gi] <= 1'b0;
               else        chain_q[gi] <= chain_q[gi-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) last_q <= 1'b0;
      else        last_q <= chain_q[STAGES-1];
   end

   assign rise_o = chain_q[STAGES-1] & ~last_q;

   AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o |=> !rise_o); // R1

endmodule

// File: rtl/ppm_prescaler.sv
module ppm_prescaler #(
   parameter int unsigned SEL_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SEL_W-1:0] sel_i,
   output logic             tick_o
);

   localparam int unsigned CNT_W = ppm_pkg::psc_cnt_width(SEL_W);

   generate
      if (SEL_W < 1 || SEL_W > 3) begin : g_bad_sel
         $error("ppm_prescaler: SEL_W must be 1 to 3");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] limit;

   always_comb limit = CNT_W'((64'd1 << sel_i) - 64'd1);

   // Compare with >= so a smaller setting takes effect at once.
   assign tick_o = (cnt_q >= limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (tick_o) cnt_q <= '0;
      else             cnt_q <= cnt_q + CNT_W'(1);
   end

   AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_o && sel_i != '0) |=> (!tick_o || sel_i == '0)); // R6

endmodule

// File: rtl/ppm_timebase.sv
module ppm_timebase #(
   parameter int unsigned TB_W = 16,
   parameter int unsigned RO_W = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 tick_i,
   output logic [TB_W+RO_W-1:0] stamp_o,
   output logic                 wrap_o
);

   logic [TB_W-1:0] tb_q;
   logic [RO_W-1:0] ro_q;

   assign wrap_o  = tick_i && (tb_q == '1);
   assign stamp_o = {ro_q, tb_q};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tb_q <= '0;
         ro_q <= '0;
      end else if (tick_i) begin
         tb_q <= tb_q + TB_W'(1);
         if (wrap_o) ro_q <= ro_q + RO_W'(1);
      end
   end

   AST_TB_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_i && tb_q == '1) |=> (tb_q == '0 && ro_q == $past(ro_q) + RO_W'(1))); // R5
   AST_TB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !tick_i |=> $stable(stamp_o)); // R6

endmodule

// File: rtl/ppm_period_calc.sv
module ppm_period_calc
   import ppm_pkg::*;
#(
   parameter int unsigned TB_W = 16,
   parameter int unsigned RO_W = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 rise_i,
   input  logic                 wrap_i,
   input  logic [TB_W+RO_W-1:0] stamp_i,
   output logic [TB_W+RO_W-1:0] period_o,
   output logic                 valid_o,
   output logic                 ovf_o
);

   localparam int unsigned TS_W = TB_W + RO_W;

   arm_state_e      arm_q;
   logic [TS_W-1:0] prev_q;
   logic [RO_W-1:0] wcnt_q;
   logic            sat;

   assign sat = (wcnt_q == '1);

   // Wraps since the last capture. A wrap in the capture cycle opens the next interval.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               wcnt_q <= '0;
      else if (rise_i)          wcnt_q <= wrap_i ? RO_W'(1) : '0;
      else if (wrap_i && !sat)  wcnt_q <= wcnt_q + RO_W'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         arm_q    <= ARM_WAIT;
         prev_q   <= '0;
         period_o <= '0;
         valid_o  <= 1'b0;
         ovf_o    <= 1'b0;
      end else begin
         valid_o <= 1'b0;
         if (rise_i) begin
            prev_q <= stamp_i;
            arm_q  <= ARM_READY;
            if (arm_q == ARM_READY) begin
               valid_o <= 1'b1;
               if (sat) begin
                  period_o <= '1;
                  ovf_o    <= 1'b1;
               end else begin
                  period_o <= stamp_i - prev_q;
                  ovf_o    <= 1'b0;
               end
            end
         end
      end
   end

   AST_COINCIDENT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (rise_i && wrap_i) |=> (wcnt_q == RO_W'(1))); // R7
   AST_VALID_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> $past(arm_q == ARM_READY)); // R3
   AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |=> !valid_o); // R2
   AST_OVF_FROM_SAT: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && ovf_o) |-> ($past(sat) && period_o == '1)); // R8

endmodule

// File: rtl/pulse_period_meter.sv
module pulse_period_meter #(
   parameter int unsigned TB_W        = 16,
   parameter int unsigned RO_W        = 16,
   parameter int unsigned PSC_SEL_W   = 2,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 sig_in,
   input  logic [PSC_SEL_W-1:0] psc_sel,
   output logic [TB_W+RO_W-1:0] period_o,
   output logic                 valid_o,
   output logic                 ovf_o
);

   localparam int unsigned TS_W = TB_W + RO_W;

   generate
      if (TB_W < 2) begin : g_bad_tb
         $error("pulse_period_meter: TB_W must be at least 2");
      end
      if (RO_W < 1) begin : g_bad_ro
         $error("pulse_period_meter: RO_W must be at least 1");
      end
      if (TS_W > 64) begin : g_bad_ts
         $error("pulse_period_meter: TB_W+RO_W must not exceed 64");
      end
   endgenerate

   logic            edge_rise;
   logic            tick;
   logic            wrap;
   logic [TS_W-1:0] stamp;

   ppm_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (sig_in),
      .rise_o  (edge_rise)
   );

   ppm_prescaler #(.SEL_W(PSC_SEL_W)) u_psc (
      .clk    (clk),
      .rst_n  (rst_n),
      .sel_i  (psc_sel),
      .tick_o (tick)
   );

   ppm_timebase #(.TB_W(TB_W), .RO_W(RO_W)) u_tb (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick_i  (tick),
      .stamp_o (stamp),
      .wrap_o  (wrap)
   );

   ppm_period_calc #(.TB_W(TB_W), .RO_W(RO_W)) u_calc (
      .clk      (clk),
      .rst_n    (rst_n),
      .rise_i   (edge_rise),
      .wrap_i   (wrap),
      .stamp_i  (stamp),
      .period_o (period_o),
      .valid_o  (valid_o),
      .ovf_o    (ovf_o)
   );

   AST_VALID_AFTER_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> $past(edge_rise)); // R1

endmodule

// File: tb/pulse_period_meter_tb.sv
module pulse_period_meter_tb;

   localparam int CLK_PERIOD = 10;
   localparam int TB_W  = 4;
   localparam int RO_W  = 3;
   localparam int SEL_W = 2;
   localparam int TS_W  = TB_W + RO_W;
   localparam int PMAX  = (1 << TS_W) - 1;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             sig_in = 1'b0;
   logic [SEL_W-1:0] psc_sel = '0;
   logic [TS_W-1:0]  period_o;
   logic             valid_o;
   logic             ovf_o;

   int checks = 0;
   int errors = 0;
   bit primed = 1'b0;
   bit skip_next = 1'b0;
   int prev_gap = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pulse_period_meter #(.TB_W(TB_W), .RO_W(RO_W), .PSC_SEL_W(SEL_W), .SYNC_STAGES(2)) u_dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .sig_in   (sig_in),
      .psc_sel  (psc_sel),
      .period_o (period_o),
      .valid_o  (valid_o),
      .ovf_o    (ovf_o)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      sig_in = 1'b0;
      @(negedge clk);
      chk(period_o == '0, "R9", "period in reset", period_o, 0);
      chk(valid_o == 1'b0, "R9", "valid in reset", valid_o, 0);
      chk(ovf_o == 1'b0, "R9", "ovf in reset", ovf_o, 0);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      primed = 1'b0;
      skip_next = 1'b0;
   endtask

   // Raise the input, hold the rising spacing at gap cycles, check the report.
   task automatic pulse(input int gap);
      int div;
      int ticks;
      div = 1 << psc_sel;
      @(negedge clk);
      sig_in = 1'b1;
      for (int i = 1; i < gap; i++) begin
         @(negedge clk);
         if (i == 1) chk(valid_o == 1'b0, "R2", "strobe before capture", valid_o, 0);
         if (i == 3) begin
            if (!primed) begin
               chk(valid_o == 1'b0, "R3", "first edge primes only", valid_o, 0);
            end else begin
               chk(valid_o == 1'b1, "R1", "strobe on third edge", valid_o, 1);
               ticks = prev_gap / div;
               if (!skip_next) begin
                  if (ticks >= PMAX + 1) begin
                     chk(ovf_o == 1'b1, "R8", "ovf flag", ovf_o, 1);
                     chk(period_o == PMAX[TS_W-1:0], "R8", "pinned period", period_o, PMAX);
                  end else if (ticks <= 6 * (1 << TB_W) - 1) begin
                     chk(ovf_o == 1'b0, "R8", "no ovf", ovf_o, 0);
                     if (div == 1)
                        chk(period_o == ticks[TS_W-1:0], "R4", "period ticks", period_o, ticks);
                     else
                        chk(period_o == ticks[TS_W-1:0], "R6", "prescaled period", period_o, ticks);
                  end
               end
            end
         end
         if (i == 4 && primed) chk(valid_o == 1'b0, "R2", "strobe one cycle", valid_o, 0);
         if (i == gap / 2) sig_in = 1'b0;
         if (i == gap / 2 + 3 && i > 4) chk(valid_o == 1'b0, "R1", "falling edge ignored", valid_o, 0);
      end
      primed = 1'b1;
      prev_gap = gap;
      skip_next = 1'b0;
   endtask

   task automatic set_sel(input int s);
      @(negedge clk);
      psc_sel = s[SEL_W-1:0];
      skip_next = 1'b1;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      do_reset();
      repeat (5) @(negedge clk);
      // R4 R5 R7: every gap 4..95; gaps above 16 cross wraps, captures hit every phase incl. wrap cycles
      for (int g = 4; g <= 95; g++) pulse(g);
      pulse(95);
      // R8: far beyond range, then back in range
      pulse(140);
      pulse(300);
      pulse(50);
      pulse(20);
      // R6: prescaled settings, gaps multiple of the divider
      for (int s = 1; s < (1 << SEL_W); s++) begin
         set_sel(s);
         for (int k = 4; k <= 44; k += 5) pulse(k << s);
         pulse(200 << s);
         pulse(30 << s);
         pulse(30 << s);
      end
      set_sel(0);
      pulse(10);
      pulse(10);
      // R9 R3: reset mid-run clears outputs and re-primes
      do_reset();
      repeat (4) @(negedge clk);
      pulse(12);
      pulse(33);
      pulse(33);
      repeat (6) @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule